// File: doc/BRIEF.md
# Pulse-Width Infrared Frame Sender

This block turns one byte into an infrared frame in which every symbol is a burst of carrier followed by a fixed silence. A symbol's value is carried only by how long its burst lasts. The carrier is produced inside the block. A clock-enable tick arrives at twice the carrier rate, and the drive line flips on each tick while a burst is active. This gives a 40 kHz square wave when the tick runs at 80 kHz.

A frame opens with a long header burst. Eight data bits follow, least significant first. Four address bits come last, and they are always zero. Bytes are offered with a valid/ready handshake. The block takes a byte only while its clear-to-send flag is high. That flag drops when a byte is taken and rises again when the silence after the final symbol ends. Between bursts and while idle, the drive line is held low.

Top module: `ir_pulse_tx`

## Requirements
- R1: After reset, `cts` and `in_ready` are 1 and `ir_out` is 0.
- R2: A byte is taken on a clock edge where `in_valid` and `in_ready` are both 1, and `in_ready` always equals `cts`. A byte offered while `cts` is 0 is dropped: the frame in progress is unchanged, and no frame follows it.
- R3: During a burst, `ir_out` flips on every tick. Each burst begins with the line low, so its first change is a rise. A burst of N ticks therefore shows N/2 rising edges.
- R4: The header burst lasts 192 ticks, which is 96 rising edges.
- R5: A data bit of 1 is a 96-tick burst (48 rising edges). A data bit of 0 is a 48-tick burst (24 rising edges). Data bits go out bit 0 first and bit 7 last.
- R6: Each burst is followed by 48 ticks of silence with `ir_out` at 0. Between two bursts the line stays low for 49 tick periods, counted from the last falling edge to the next rising edge.
- R7: After the eight data bits, four address bits are sent, each coded as 0 (a 24-edge burst). A frame has 13 bursts in total.
- R8: `cts` drops on the edge that takes the byte. It rises on the tick edge that ends the last silence, so it stays low for 240 + 144·(ones in byte) + 96·(8 − ones + 4) tick periods.
- R9: Without a tick, `ir_out` and the frame position hold their values. A byte is still taken without a tick, but the line stays low until the first tick arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Clock enable at twice the carrier rate |
| in_data | input | 8 | Byte to send |
| in_valid | input | 1 | `in_data` is offered |
| in_ready | output | 1 | Byte can be taken (equals `cts`) |
| ir_out | output | 1 | Modulated infrared drive line |
| cts | output | 1 | Clear to send: high when idle |

## Verification
A wrong burst length or a wrong bit order changes the number of rising edges in a particular burst. The bench counts those edges burst by burst, so the error shows within the same frame. A fault in the silence counter changes both the low run between bursts and the overall length of `cts` low, and both are compared to exact tick counts. A phase register that is not cleared shows up as a burst that starts with a fall, or as one missing edge, on the first tick after the byte is taken. A busy flag that is lost shows up as a second frame, or as `cts` rising early, within a few hundred cycles of the offered byte.

// File: rtl/ir_pulse_tx.sv
module ir_pulse_tx #(
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 4,
  parameter int START_T = 192,
  parameter int ONE_T   = 96,
  parameter int ZERO_T  = 48,
  parameter int GAP_T   = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  output logic              ir_out,
  output logic              cts
);
  localparam int NBITS = DATA_W + ADDR_W;
  localparam int CW = $clog2(START_T + 1);
  localparam int BW = $clog2(NBITS + 1);

  logic             busy, in_mark, phase;
  logic [CW-1:0]    rem;
  logic [BW-1:0]    left;
  logic [NBITS-1:0] sh;

  assign cts      = ~busy;
  assign in_ready = ~busy;
  assign ir_out   = phase;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      in_mark <= 1'b0;
      phase   <= 1'b0;
      rem     <= '0;
      left    <= '0;
      sh      <= '0;
    end else if (!busy) begin
      if (in_valid) begin
        busy    <= 1'b1;
        in_mark <= 1'b1;
        phase   <= 1'b0;
        rem     <= CW'(START_T);
        left    <= BW'(NBITS);
        sh      <= {{ADDR_W{1'b0}}, in_data};
      end
    end else if (tick) begin
      if (in_mark) begin
        if (rem == CW'(1)) begin
          in_mark <= 1'b0;
          phase   <= 1'b0;
          rem     <= CW'(GAP_T);
        end else begin
          phase <= ~phase;
          rem   <= rem - CW'(1);
        end
      end else if (rem == CW'(1)) begin
        if (left == '0) begin
          busy <= 1'b0;
        end else begin
          in_mark <= 1'b1;
          phase   <= 1'b0;
          rem     <= sh[0] ? CW'(ONE_T) : CW'(ZERO_T);
          sh      <= sh >> 1;
          left    <= left - BW'(1);
        end
      end else begin
        rem <= rem - CW'(1);
      end
    end
  end
endmodule

// File: rtl/ir_pulse_tx_chk.sv
module ir_pulse_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic in_valid,
  input logic in_ready,
  input logic ir_out,
  input logic cts
);
  // R1
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cts |-> !ir_out);

  // R2
  take_drops_cts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !cts);

  // R2
  stay_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cts && !in_valid) |=> cts);

  // R9
  hold_without_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(ir_out));

  // R8
  cts_rise_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cts) |-> $past(tick));

  // R8
  cts_end_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cts) |-> !ir_out);
endmodule

bind ir_pulse_tx ir_pulse_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .in_valid(in_valid),
  .in_ready(in_ready), .ir_out(ir_out), .cts(cts)
);

// File: tb/ir_pulse_tx_tb.sv
module ir_pulse_tx_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_valid = 1'b0;
  logic       in_ready, ir_out, cts;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ir_pulse_tx u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .in_data(in_data),
    .in_valid(in_valid), .in_ready(in_ready), .ir_out(ir_out), .cts(cts)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 cts", cts, 1);
    check("R1 in_ready", in_ready, 1);
    check("R1 ir_out", ir_out, 0);
  endtask

  task automatic t_frame(input logic [7:0] d, input int per, input bit offer);
    int edges[16];
    int lows[16];
    int nb = -1;
    int lowcnt = 0;
    int lowcyc = 0;
    int ones = 0;
    int iter = 0;
    bit prev = 1'b0;
    bit saw_busy_ready = 1'b0;
    for (int i = 0; i < 16; i++) begin edges[i] = 0; lows[i] = 0; end
    for (int i = 0; i < 8; i++) ones += d[i];
    @(negedge clk);
    tick = 1'b0;
    check("R2 ready before offer", in_ready, 1);
    in_data = d;
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check("R8 cts drops on take", cts, 0);
    while (iter < 20000) begin
      if (iter > 0) @(negedge clk);
      if (cts) break;
      lowcyc++;
      if (ir_out && !prev) begin
        if (nb < 0 || lowcnt > 4 * per) begin
          nb++;
          if (nb < 16) lows[nb] = lowcnt;
        end
        if (nb >= 0 && nb < 16) edges[nb]++;
      end
      if (ir_out) lowcnt = 0; else lowcnt++;
      prev = ir_out;
      if (offer && iter >= 100 && iter < 110) begin
        in_valid = 1'b1;
        in_data = ~d;
        if (in_ready) saw_busy_ready = 1'b1;
      end else begin
        in_valid = 1'b0;
      end
      tick = ((iter % per) == per - 1);
      iter++;
    end
    in_valid = 1'b0;
    tick = 1'b0;
    check("R7 burst count", nb + 1, 13);
    check("R4 header edges", edges[0], 96);
    for (int i = 0; i < 8; i++)
      check($sformatf("R5 data bit %0d edges", i), edges[i + 1], d[i] ? 48 : 24);
    for (int i = 0; i < 4; i++)
      check($sformatf("R7 address bit %0d edges", i), edges[i + 9], 24);
    for (int i = 1; i < 13; i++)
      check($sformatf("R6 gap before burst %0d", i), lows[i], 49 * per);
    check("R8 cts low length", lowcyc, per * (240 + 144 * ones + 96 * (12 - ones)));
    check("R6 line low at end", ir_out, 0);
    if (offer) begin
      check("R2 ready low while busy", saw_busy_ready, 0);
      for (int k = 0; k < 300; k++) begin
        @(negedge clk);
        tick = 1'b1;
        if (!cts || ir_out) break;
      end
      @(negedge clk);
      tick = 1'b0;
      check("R2 dropped byte starts nothing (cts)", cts, 1);
      check("R2 dropped byte starts nothing (ir_out)", ir_out, 0);
    end
  endtask

  task automatic t_hold();
    int guard = 0;
    @(negedge clk);
    tick = 1'b0;
    in_data = 8'h3C;
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check("R9 taken without tick", cts, 0);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (ir_out) break;
    end
    check("R9 line low without tick", ir_out, 0);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    check("R3 first change is a rise", ir_out, 1);
    repeat (5) @(negedge clk);
    check("R9 level held without tick", ir_out, 1);
    tick = 1'b1;
    @(negedge clk);
    check("R3 flips on next tick", ir_out, 0);
    while (!cts && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    tick = 1'b0;
    check("R8 frame completes", cts, 1);
  endtask

  initial begin
    t_reset();
    t_frame(8'hA5, 1, 1'b0);
    t_frame(8'h00, 1, 1'b0);
    t_frame(8'hFF, 3, 1'b0);
    t_frame(8'h81, 2, 1'b1);
    t_hold();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule